// File: doc/BRIEF.md
# MDIO Station Management Controller

This block runs single management transactions to an external PHY over a two-wire serial management link. Software loads a 16-bit data register and then writes a 12-bit command word. If the go bit is set in that word, the controller latches the PHY address, register address and direction and starts a frame. The frame is serialised MSB first on the data line and clocked by a management clock derived from the system clock.

The management clock period is 2 × (div + 1) system clocks. For a 2.5 MHz management clock from a 250 MHz system clock, div is 49. While a frame is in flight the busy output is high. Busy drops by itself on the falling clock edge that ends the last bit. For a read, the data register already holds the 16 bits returned by the PHY in the cycle in which busy is first seen low. Command writes made while busy are dropped.

Top module: `mdio_station_ctrl`

## Requirements
- R1: The command word has phy address in bits [4:0], register address in bits [9:5], direction in bit 10 (1 = write, 0 = read) and go in bit 11. When `cmd_wr` is high with bit 11 set while idle, a transaction starts: busy is high from the next cycle. A command write with bit 11 clear starts nothing.
- R2: Busy stays high for exactly 128 × (div + 1) cycles and then clears without any software action. This figure assumes a 32-bit preamble.
- R3: `mdc` is low whenever the controller is idle. Within a transaction, `mdc` first rises div + 1 cycles after the start edge and then toggles every div + 1 cycles. The divisor is latched at the start, so changing `cfg_div` mid-frame has no effect on that frame.
- R4: The frame carries 32 ones, then start `01`, then opcode `01` for a write or `10` for a read, then the 5-bit phy address and the 5-bit register address, each MSB first.
- R5: In a write, the register address is followed by turnaround `10` and then the 16 data bits that the data register held at the start, MSB first. The output enable stays high for the whole frame.
- R6: In a read, `mdio_oe` goes low at the first turnaround bit and stays low until the end. Each data bit is sampled from `mdio_i` at the rising edge of `mdc`. The 16-bit result is in `rd_data` in the first cycle in which busy is low.
- R7: While busy, `mdio_o` changes only in the cycle in which `mdc` falls.
- R8: A command write while busy is ignored. The frame in flight, its divisor and its duration are unchanged, and no further transaction follows.
- R9: A data write loads `rd_data` on the next cycle, including while busy. A write transaction leaves the data register unchanged. A read result that completes in the same cycle as a data write takes priority.
- R10: After reset, busy, `mdc`, `mdio_oe` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Clock divisor, latched at transaction start |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 12 | Command word: phy, register, direction, go |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register write value |
| busy | output | 1 | Transaction in progress |
| rd_data | output | 16 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable (0 = released) |
| mdio_i | input | 1 | Serial data in from the PHY |

## Verification
The hardest case to reach from the ports is proving that read data is taken on the rising edge and not on the falling one. A PHY that holds its bit for a whole period cannot tell the two apart. The bench PHY therefore drives the correct bit only while `mdc` is low and the inverted bit while it is high, so a falling-edge sample returns the complement. Dropped command writes, mid-frame divisor and data changes, and a start issued in the very first idle cycle are driven at chosen cycles inside live frames. The cycle-level model then catches any disturbance of the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int PHY_W   = 5;
   localparam int REG_W   = 5;
   localparam int DATA_W  = 16;
   localparam int CMD_W   = 12;
   localparam int BODY_W  = 32;
   localparam int PHY_LSB = 0;
   localparam int REG_LSB = 5;
   localparam int DIR_BIT = 10;
   localparam int GO_BIT  = 11;

   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] OPC_WR   = 2'b01;
   localparam logic [1:0] OPC_RD   = 2'b10;
   localparam logic [1:0] TA_WR    = 2'b10;
   localparam logic [1:0] TA_RD    = 2'b11;

   typedef struct packed {
      logic             is_wr;
      logic [PHY_W-1:0] phy;
      logic [REG_W-1:0] regad;
   } mdio_cmd_t;

   function automatic mdio_cmd_t decode_cmd(input logic [CMD_W-1:0] w);
      mdio_cmd_t c;
      c.is_wr = w[DIR_BIT];
      c.phy   = w[PHY_LSB +: PHY_W];
      c.regad = w[REG_LSB +: REG_W];
      return c;
   endfunction

   function automatic logic [BODY_W-1:0] frame_body(input mdio_cmd_t c,
                                                    input logic [DATA_W-1:0] d);
      return {SOF_CODE, (c.is_wr ? OPC_WR : OPC_RD), c.phy, c.regad,
              (c.is_wr ? TA_WR : TA_RD), d};
   endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);
   logic [DIV_W-1:0] cnt_q;
   logic             mdc_q;
   logic             wrap;

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("DIV_W out of range");
   end

   assign wrap     = run && (cnt_q == div);
   assign rise_stb = wrap && !mdc_q;
   assign fall_stb = wrap && mdc_q;
   assign mdc      = mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3
   half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= div));

   // R3
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN         = 32,
   parameter bit CAPTURE_ON_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mdio_cmd_t         cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_i,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              rd_vld,
   output logic [DATA_W-1:0] rd_word
);
   localparam int FRAME_LEN = PRE_LEN + BODY_W;
   localparam int IDX_W     = $clog2(FRAME_LEN + 1);
   localparam int TA_IDX    = PRE_LEN + 14;
   localparam int DATA_IDX  = PRE_LEN + 16;
   localparam int LAST_IDX  = FRAME_LEN - 1;

   logic [FRAME_LEN-1:0] shf_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 busy_q;
   logic                 rd_q;
   logic                 oe_q;
   logic [DATA_W-1:0]    cap_q;
   logic [DATA_W-1:0]    cap_nxt;
   logic                 smp_stb;
   logic                 take_bit;
   logic                 last_fall;

   initial begin
      assert (PRE_LEN >= 1 && PRE_LEN <= 64) else $error("PRE_LEN out of range");
   end

   generate
      if (CAPTURE_ON_RISE) begin : g_smp_rise
         assign smp_stb = rise_stb;
      end else begin : g_smp_fall
         assign smp_stb = fall_stb;
      end
   endgenerate

   assign cap_nxt   = {cap_q[DATA_W-2:0], mdio_i};
   assign take_bit  = busy_q && rd_q && smp_stb && (idx_q >= IDX_W'(DATA_IDX));
   assign last_fall = busy_q && fall_stb && (idx_q == IDX_W'(LAST_IDX));
   assign rd_word   = take_bit ? cap_nxt : cap_q;
   assign rd_vld    = last_fall && rd_q;
   assign busy      = busy_q;
   assign mdio_o    = shf_q[FRAME_LEN-1];
   assign mdio_oe   = oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shf_q  <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
         oe_q   <= 1'b0;
         cap_q  <= '0;
      end else if (start) begin
         shf_q  <= {{PRE_LEN{1'b1}}, frame_body(cmd, wdata)};
         idx_q  <= '0;
         busy_q <= 1'b1;
         rd_q   <= !cmd.is_wr;
         oe_q   <= 1'b1;
         cap_q  <= '0;
      end else if (busy_q) begin
         if (take_bit) cap_q <= cap_nxt;
         if (fall_stb) begin
            if (last_fall) begin
               busy_q <= 1'b0;
               oe_q   <= 1'b0;
            end else begin
               shf_q <= {shf_q[FRAME_LEN-2:0], 1'b0};
               idx_q <= idx_q + 1'b1;
               if (rd_q && idx_q == IDX_W'(TA_IDX - 1)) oe_q <= 1'b0;
            end
         end
      end
   end

   // R7
   out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$stable(shf_q[FRAME_LEN-1])) |-> $past(fall_stb));

   // R2
   end_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ($past(idx_q) == IDX_W'(LAST_IDX)));

   // R6
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && rd_q && idx_q >= IDX_W'(TA_IDX)) |-> !oe_q);

   // R5
   wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !rd_q) |-> oe_q);
endmodule

// File: rtl/mdio_station_ctrl.sv
module mdio_station_ctrl
   import mdio_pkg::*;
#(
   parameter int DIV_W           = 8,
   parameter int PRE_LEN         = 32,
   parameter bit CAPTURE_ON_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_wdata,
   output logic              busy,
   output logic [DATA_W-1:0] rd_data,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] dreg_q;
   logic              busy_w;
   logic              start;
   logic              rise_stb;
   logic              fall_stb;
   logic              rd_vld;
   logic [DATA_W-1:0] rd_word;
   mdio_cmd_t         cmd_w;

   assign cmd_w   = decode_cmd(cmd_wdata);
   assign start   = cmd_wr && cmd_wdata[GO_BIT] && !busy_w;
   assign busy    = busy_w;
   assign rd_data = dreg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         dreg_q <= '0;
      end else begin
         if (start) div_q <= cfg_div;
         if (rd_vld) dreg_q <= rd_word;
         else if (data_wr) dreg_q <= data_wdata;
      end
   end

   mdio_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy_w),
      .div      (div_q),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_seq #(.PRE_LEN(PRE_LEN), .CAPTURE_ON_RISE(CAPTURE_ON_RISE)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmd      (cmd_w),
      .wdata    (dreg_q),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .busy     (busy_w),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_vld   (rd_vld),
      .rd_word  (rd_word)
   );

   // R1
   go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_wdata[GO_BIT] && !busy_w) |=> busy_w);

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && cmd_wr) |=> $stable(div_q));

   // R9
   data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !rd_vld) |=> (dreg_q == $past(data_wdata)));
endmodule

// File: tb/sim_mdio_station_ctrl.sv
module sim_mdio_station_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_div = 8'd0;
   logic        cmd_wr = 1'b0;
   logic [11:0] cmd_wdata = 12'd0;
   logic        data_wr = 1'b0;
   logic [15:0] data_wdata = 16'd0;
   logic        busy, mdc, mdio_o, mdio_oe;
   logic [15:0] rd_data;
   logic        mdio_i = 1'b1;

   always #2 clk = ~clk;

   mdio_station_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cmd_wr(cmd_wr),
      .cmd_wdata(cmd_wdata), .data_wr(data_wr), .data_wdata(data_wdata),
      .busy(busy), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   // behavioural reference state
   int          t = 0;
   int          h = 1;
   bit          m_busy = 0;
   bit          m_rd = 0;
   logic [4:0]  m_phy = 0, m_reg = 0;
   logic [15:0] m_wd = 0, m_dreg = 0;
   logic [15:0] phy_val = 16'h0000;

   function automatic bit m_mdc();
      return m_busy ? (((t / h) % 2) == 1) : 1'b0;
   endfunction

   function automatic int m_idx();
      return t / (2 * h);
   endfunction

   function automatic bit m_oe();
      return m_busy && !(m_rd && m_idx() >= 46);
   endfunction

   function automatic bit exp_bit(int i);
      logic [31:0] body;
      body = {2'b01, (m_rd ? 2'b10 : 2'b01), m_phy, m_reg, 2'b10, m_wd};
      if (i < 32) return 1'b1;
      return body[31 - (i - 32)];
   endfunction

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; t = 0; m_dreg = 0;
      end else begin
         bit was;
         was = m_busy;
         if (data_wr) m_dreg = data_wdata;
         if (m_busy) begin
            t++;
            if (t == 128 * h) begin
               m_busy = 0;
               if (m_rd) m_dreg = phy_val;
            end
         end
         if (!was && cmd_wr && cmd_wdata[11]) begin
            m_busy = 1; t = 0; h = int'(cfg_div) + 1;
            m_rd = !cmd_wdata[10];
            m_phy = cmd_wdata[4:0];
            m_reg = cmd_wdata[9:5];
            m_wd = m_dreg;
         end
      end
   end

   // compare on every clock and drive the PHY side
   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 busy", int'(busy), int'(m_busy));
         check("R3 mdc", int'(mdc), int'(m_mdc()));
         check("R6 mdio_oe", int'(mdio_oe), int'(m_oe()));
         check("R9 rd_data", int'(rd_data), int'(m_dreg));
         if (m_oe())
            check(m_idx() < 46 ? "R4 mdio_o" : "R5 mdio_o", int'(mdio_o),
                  int'(exp_bit(m_idx())));
      end
      // bench PHY: true bit while mdc low, complement while high
      if (m_busy && m_rd && m_idx() >= 48) begin
         bit b;
         b = phy_val[15 - (m_idx() - 48)];
         mdio_i <= m_mdc() ? ~b : b;
      end else begin
         mdio_i <= 1'b1;
      end
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   task automatic put_cmd(logic [11:0] w);
      cmd_wdata = w; cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic put_data(logic [15:0] w);
      data_wdata = w; data_wr = 1'b1;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   // cmd word: [4:0] phy, [9:5] reg, [10] 1=write, [11] go
   function automatic logic [11:0] mk(bit go, bit wr, logic [4:0] rg, logic [4:0] ph);
      return {go, wr, rg, ph};
   endfunction

   initial begin
      int len;
      @(negedge clk);
      @(negedge clk);
      // R10 reset state
      check("R10 busy", int'(busy), 0);
      check("R10 mdc", int'(mdc), 0);
      check("R10 mdio_oe", int'(mdio_oe), 0);
      check("R10 rd_data", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 go clear starts nothing
      put_cmd(mk(0, 1, 5'd3, 5'd1));
      wait_n(3);
      check("R1 no start", int'(busy), 0);

      // R5 write, div 0, with R8 dropped command and R3 divisor change mid-frame
      put_data(16'h1234);
      cfg_div = 8'd0;
      put_cmd(mk(1, 1, 5'd0, 5'd1));
      check("R1 busy after go", int'(busy), 1);
      wait_n(20);
      cfg_div = 8'd5;
      put_cmd(mk(1, 0, 5'd31, 5'd31));
      wait_idle();
      wait_n(4);
      check("R8 no follow-on", int'(busy), 0);
      check("R9 write keeps dreg", int'(rd_data), 16'h1234);

      // R6 read at div 1
      cfg_div = 8'd1; phy_val = 16'hA5C3;
      put_cmd(mk(1, 0, 5'd1, 5'd1));
      wait_idle();
      check("R6 read result", int'(rd_data), 16'hA5C3);

      // R6/R9 read at div 3 with data write in flight
      cfg_div = 8'd3; phy_val = 16'h5A3C;
      put_cmd(mk(1, 0, 5'd17, 5'd22));
      wait_n(100);
      put_data(16'hFFFF);
      check("R9 load while busy", int'(rd_data), 16'hFFFF);
      wait_idle();
      check("R6 read overrides", int'(rd_data), 16'h5A3C);

      // R2 duration at div 2, write uses data latched at start
      cfg_div = 8'd2;
      put_data(16'hBEEF);
      put_cmd(mk(1, 1, 5'd9, 5'd4));
      len = 1;
      wait_n(50);
      len += 50;
      put_data(16'h0000);
      len += 1;
      while (busy) begin @(negedge clk); len++; end
      check("R2 busy length", len - 1, 128 * 3);

      // back-to-back: read issued in the first idle cycle
      cfg_div = 8'd0; phy_val = 16'h8001;
      put_cmd(mk(1, 0, 5'd2, 5'd1));
      wait_idle();
      check("R6 back-to-back read", int'(rd_data), 16'h8001);
      wait_n(5);
      finish_run();
   end
endmodule